// File: doc/BRIEF.md
# I2C Register Read/Write Target

This block is the serial front end of a bank of 16-bit configuration registers. It sits on an open-drain two-wire bus, where each line is seen as a plain input and pulled down through a drive-low enable. The bank itself lives outside the block and is reached through a narrow parallel port: an 8-bit register select, a 16-bit read-data input, and a one-cycle write strobe with 16-bit write data.

A controller writes a register by sending the target address with a write direction bit, a command byte naming the register, and then the high and low data bytes. It reads a register in one of two ways. In the combined form, it sends the command byte in a write phase and then issues a repeated START with the read direction bit. In the short form, it opens a read with no command byte, and the block returns whichever register was written most recently. Data always leaves the block high byte first, and the low byte is sent only if the controller acknowledged the high byte. A second, broadcast address accepts writes but refuses reads.

Both bus lines pass through synchronizers into the system clock domain. START, STOP and clock edges are then found by comparing consecutive synchronized samples.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal TGT_ADDR is acknowledged (SDA held low in the ninth clock) for both direction bits (bit 0: 0 = write, 1 = read).
- R2: An address byte matching neither TGT_ADDR nor BCAST_ADDR is not acknowledged, and the block then leaves SDA released until the next START, so a following byte reads as FFh.
- R3: In a write phase the command byte is acknowledged. A repeated START with the read bit then returns the register that the command byte named.
- R4: Read data goes out as two bytes, bits 15..8 first and bits 7..0 second, each byte MSB first.
- R5: The low byte is sent only after the controller acknowledges the high byte. After a controller NACK the block releases SDA until the next START or STOP.
- R6: A read that has no command byte since the last STOP returns the register most recently written. Out of reset that register is LAST_RST (D0h by default).
- R7: The broadcast address BCAST_ADDR is acknowledged with the write bit and acts like TGT_ADDR for writes. With the read bit it is NACKed and no data is driven.
- R8: Address, command, high byte and low byte together produce exactly one single-cycle rf_wr pulse, with rf_sel equal to the command byte and rf_wdata equal to {high, low}. The same transfer records that command as the last-written register.
- R9: The block changes its SDA drive only while the synchronized SCL is low.
- R10: While reset is applied and after it is released, sda_oe and rf_wr are low until bus traffic arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| rf_sel | output | 8 | Register select to the bank |
| rf_rdata | input | 16 | Data of the selected register |
| rf_wr | output | 1 | One-cycle write strobe |
| rf_wdata | output | 16 | Data for the selected register |

## Verification
Two functions can act on the read pointer in the same cycle: the register write at the end of a write transfer, and the choice of which register feeds the read shifter. To bring them together, the bench follows a complete write with a repeated START and a read, with no STOP in between. The bytes that come back must be the value just written, not the value the register held before. The same run also checks that only one write strobe was seen.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_WMSB, PH_WLSB
  } ph_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic dout_d
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else        chain[g] <= chain[g-1];
    end
  end

  assign dout   = chain[STAGES-1];
  assign dout_d = chain[STAGES];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic scl_s,
  input  logic scl_d,
  input  logic sda_s,
  input  logic sda_d,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_hi;
  always_comb begin
    scl_hi    = scl_s & scl_d;
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    bus_start = scl_hi & sda_d & ~sda_s;
    bus_stop  = scl_hi & ~sda_d & sda_s;
  end
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR   = 7'h48,
  parameter logic [6:0] BCAST_ADDR = 7'h47,
  parameter logic [7:0] LAST_RST   = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rf_sel,
  input  logic [REG_W-1:0]  rf_rdata,
  output logic              rf_wr,
  output logic [REG_W-1:0]  rf_wdata
);
  st_e               st, st_n;
  ph_e               ph, ph_n;
  logic [CNT_W-1:0]  bcnt, bcnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n;
  logic [BYTE_W-1:0] ptr, ptr_n;
  logic [BYTE_W-1:0] last, last_n;
  logic [BYTE_W-1:0] msb, msb_n;
  logic [REG_W-1:0]  txsh, txsh_n;
  logic [REG_W-1:0]  wdata, wdata_n;
  logic              rw, rw_n;
  logic              cmd_ok, cmd_ok_n;
  logic              second, second_n;
  logic              acked, acked_n;
  logic              we, we_n;
  logic              byte_done, addr_hit;

  always_comb begin
    byte_done = scl_fall && (bcnt == CNT_W'(BYTE_W));
    addr_hit  = (shreg[7:1] == TGT_ADDR) ||
                ((shreg[7:1] == BCAST_ADDR) && !shreg[0]);
  end

  always_comb begin
    st_n = st;  ph_n = ph;  bcnt_n = bcnt;  shreg_n = shreg;
    ptr_n = ptr;  last_n = last;  msb_n = msb;  txsh_n = txsh;
    wdata_n = wdata;  rw_n = rw;  cmd_ok_n = cmd_ok;
    second_n = second;  acked_n = acked;  we_n = 1'b0;
    if (bus_stop) begin
      st_n     = ST_IDLE;
      cmd_ok_n = 1'b0;
    end else if (bus_start) begin
      st_n   = ST_RX;
      ph_n   = PH_ADDR;
      bcnt_n = '0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg_n = {shreg[BYTE_W-2:0], sda_s};
            bcnt_n  = bcnt + 1'b1;
          end else if (byte_done) begin
            bcnt_n = '0;
            unique case (ph)
              PH_ADDR: begin
                rw_n = shreg[0];
                st_n = addr_hit ? ST_RX_ACK : ST_WAIT;
              end
              PH_CMD: begin
                ptr_n    = shreg;
                cmd_ok_n = 1'b1;
                st_n     = ST_RX_ACK;
              end
              PH_WMSB: begin
                msb_n = shreg;
                st_n  = ST_RX_ACK;
              end
              default: begin
                we_n    = 1'b1;
                wdata_n = {msb, shreg};
                last_n  = ptr;
                st_n    = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (ph == PH_ADDR && rw) begin
              st_n     = ST_TX;
              txsh_n   = rf_rdata;
              second_n = 1'b0;
              bcnt_n   = '0;
            end else begin
              unique case (ph)
                PH_ADDR: begin ph_n = PH_CMD;  st_n = ST_RX;   end
                PH_CMD:  begin ph_n = PH_WMSB; st_n = ST_RX;   end
                PH_WMSB: begin ph_n = PH_WLSB; st_n = ST_RX;   end
                default: begin                 st_n = ST_WAIT; end
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            txsh_n = {txsh[REG_W-2:0], 1'b1};
            bcnt_n = bcnt + 1'b1;
            if (bcnt == CNT_W'(BYTE_W - 1)) st_n = ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            acked_n = !sda_s;
          end else if (scl_fall) begin
            bcnt_n = '0;
            if (acked && !second) begin
              st_n     = ST_TX;
              second_n = 1'b1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  ph <= PH_ADDR;  bcnt <= '0;  shreg <= '0;
      ptr <= LAST_RST;  last <= LAST_RST;  msb <= '0;  txsh <= '1;
      wdata <= '0;  rw <= 1'b0;  cmd_ok <= 1'b0;  second <= 1'b0;
      acked <= 1'b0;  we <= 1'b0;
    end else begin
      st <= st_n;  ph <= ph_n;  bcnt <= bcnt_n;  shreg <= shreg_n;
      ptr <= ptr_n;  last <= last_n;  msb <= msb_n;  txsh <= txsh_n;
      wdata <= wdata_n;  rw <= rw_n;  cmd_ok <= cmd_ok_n;
      second <= second_n;  acked <= acked_n;  we <= we_n;
    end
  end

  always_comb begin
    sda_oe   = (st == ST_RX_ACK) || ((st == ST_TX) && !txsh[REG_W-1]);
    rf_sel   = cmd_ok ? ptr : last;
    rf_wr    = we;
    rf_wdata = wdata;
  end

  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  assert_bcast_rd_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX_ACK && ph == PH_ADDR) |-> !(shreg[0] && shreg[7:1] == BCAST_ADDR));
  assert_tx_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX) |-> rw);
  assert_wait_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe);
  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h48,
  parameter logic [6:0] BCAST_ADDR  = 7'h47,
  parameter logic [7:0] LAST_RST    = 8'hD0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  rf_sel,
  input  logic [15:0] rf_rdata,
  output logic        rf_wr,
  output logic [15:0] rf_wdata
);
  logic [1:0] rst_q;
  logic       rst_sn;
  logic       scl_s, scl_d, sda_s, sda_d;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_sn), .din(scl_i), .dout(scl_s), .dout_d(scl_d));
  i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_sn), .din(sda_i), .dout(sda_s), .dout_d(sda_d));

  i2ct_cond u_cond (
    .scl_s(scl_s), .scl_d(scl_d), .sda_s(sda_s), .sda_d(sda_d),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop));

  i2ct_fsm #(.TGT_ADDR(TGT_ADDR), .BCAST_ADDR(BCAST_ADDR), .LAST_RST(LAST_RST)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_oe(sda_oe), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
    .rf_wr(rf_wr), .rf_wdata(rf_wdata));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_sn |=> !sda_oe && !rf_wr);
endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam logic [6:0] TGT = 7'h48;
  localparam logic [6:0] BC  = 7'h47;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe, rf_wr;
  logic [7:0] rf_sel;
  logic [15:0] rf_rdata, rf_wdata;
  logic sda_line;
  logic [15:0] bank [256];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] obs;
  event obs_ev;

  always #4 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;
  assign rf_rdata = bank[rf_sel];

  i2c_reg_target #(.TGT_ADDR(TGT), .BCAST_ADDR(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rf_sel(rf_sel), .rf_rdata(rf_rdata), .rf_wr(rf_wr), .rf_wdata(rf_wdata));

  always @(posedge clk) if (rf_wr) begin
    bank[rf_sel] <= rf_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  always begin
    @(obs_ev);
    if (exp_q.size() == 0) chk(1'b0, "unexpected byte", obs, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(obs == e, t, obs, e);
    end
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start();
    sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_drv = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_drv = 1'b1; wq(Q);
  endtask
  task automatic put_bit(input logic b);
    sda_drv = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic send(input logic [7:0] d, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    chk((a == 1'b0) == exp_ack, req, a, !exp_ack);
  endtask
  task automatic recv(input logic [7:0] e, input bit give_ack, input string req);
    logic [7:0] d;
    exp_q.push_back(e); tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!give_ack);
    obs = d; ->obs_ev; wq(1);
  endtask
  task automatic write_reg(input logic [6:0] a, input logic [7:0] c, input logic [15:0] v);
    bus_start(); send({a, 1'b0}, 1, "R1 addr ack");
    send(c, 1, "R3 cmd ack"); send(v[15:8], 1, "R8 msb ack"); send(v[7:0], 1, "R8 lsb ack");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bank[i] = 16'h0000;
    bank[8'hD0] = 16'h000C; bank[8'hD1] = 16'h01F0; bank[8'hD3] = 16'h0008;
    wq(3);
    chk(sda_oe == 1'b0, "R10 sda_oe in reset", sda_oe, 0);
    chk(rf_wr == 1'b0, "R10 rf_wr in reset", rf_wr, 0);
    rst_n = 1'b1; wq(10);
    chk(sda_oe == 1'b0 && rf_wr == 1'b0, "R10 quiet after reset", {sda_oe, rf_wr}, 0);

    bus_start(); send({TGT, 1'b1}, 1, "R1 read addr ack");
    recv(8'h00, 1, "R6 reset pointer msb"); recv(8'h0C, 0, "R6 reset pointer lsb");
    bus_stop();

    bus_start(); send({TGT, 1'b0}, 1, "R1 write addr ack"); send(8'hD1, 1, "R3 cmd ack");
    bus_start(); send({TGT, 1'b1}, 1, "R3 sr addr ack");
    recv(8'h01, 1, "R4 msb first"); recv(8'hF0, 0, "R4 lsb second");
    bus_stop();

    write_reg(TGT, 8'h21, 16'hA55A); bus_stop(); wq(2);
    chk(wr_cnt == 1, "R8 one strobe", wr_cnt, 1);
    chk(bank[8'h21] == 16'hA55A, "R8 bank data", bank[8'h21], 16'hA55A);
    bus_start(); send({TGT, 1'b1}, 1, "R6 addr ack");
    recv(8'hA5, 1, "R6 last written msb"); recv(8'h5A, 0, "R6 last written lsb");
    bus_stop();

    bus_start(); send({7'h11, 1'b0}, 0, "R2 foreign write nack");
    send(8'hD1, 0, "R2 ignored after nack"); bus_stop();
    bus_start(); send({7'h11, 1'b1}, 0, "R2 foreign read nack");
    recv(8'hFF, 0, "R2 line released"); bus_stop();
    chk(wr_cnt == 1, "R2 no strobe", wr_cnt, 1);

    bus_start(); send({BC, 1'b0}, 1, "R7 bcast write ack");
    send(8'hD3, 1, "R7 cmd"); send(8'h12, 1, "R7 msb"); send(8'h34, 1, "R7 lsb");
    bus_stop(); wq(2);
    chk(bank[8'hD3] == 16'h1234, "R7 bcast write applied", bank[8'hD3], 16'h1234);
    bus_start(); send({BC, 1'b1}, 0, "R7 bcast read nack");
    recv(8'hFF, 0, "R7 no data driven"); bus_stop();
    bus_start(); send({TGT, 1'b0}, 1, "R3 addr"); send(8'hD3, 1, "R3 cmd");
    bus_start(); send({TGT, 1'b1}, 1, "R3 sr");
    recv(8'h12, 1, "R3 named reg msb"); recv(8'h34, 0, "R3 named reg lsb"); bus_stop();

    bus_start(); send({TGT, 1'b0}, 1, "R5 addr"); send(8'hD1, 1, "R5 cmd");
    bus_start(); send({TGT, 1'b1}, 1, "R5 sr");
    recv(8'h01, 0, "R5 msb nacked"); recv(8'hFF, 0, "R5 no lsb after nack"); bus_stop();

    write_reg(TGT, 8'h21, 16'h0F3C);
    bus_start(); send({TGT, 1'b1}, 1, "R6 sr after write");
    recv(8'h0F, 1, "R6 fresh msb"); recv(8'h3C, 0, "R6 fresh lsb"); bus_stop(); wq(2);
    chk(wr_cnt == 3, "R8 strobe count", wr_cnt, 3);

    wq(20);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog got=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule